// File: doc/BRIEF.md
# Isolated I/O Port Decoder

This block sits beside a processor bus that keeps I/O ports in their own address space, separate from memory. Each bus cycle is announced by a one-cycle start pulse that comes with a memory-or-I/O status line, a write-or-read status line, an address and a high-byte enable. The block turns that status into distinct I/O read and I/O write command strobes. It matches the low 16 address bits against parameterised port numbers and raises a select for one 8-bit input port and for each byte of an output port.

The input port returns the state of a bank of switches on its byte lane of the 16-bit read bus. It drives that lane only while it is selected. The output port latches its byte lane of the write data into a register whose bits drive active-low indicators. A port address can come as a short 8-bit number, which is zero-extended, or as a full 16-bit number.

Lanes follow the usual 16-bit I/O banking. Even ports sit on data bits 7..0 and are enabled when address bit 0 is low. Odd ports sit on bits 15..8 and are enabled by the active-low high-byte enable.

A small cycle state machine sequences every access. It has four states:
- `ST_IDLE` waits for a start pulse.
- `ST_IO_RD` asserts the read command for one cycle.
- `ST_IO_WR` asserts the write command for one cycle.
- `ST_MEM_PASS` absorbs a memory cycle for one cycle without any command.

Its transitions are:
- idle-to-read on a start of an I/O read.
- idle-to-write on a start of an I/O write.
- idle-to-pass on a start of a memory cycle.
- return-to-idle from each of the three busy states after one cycle.
- stay-idle when there is no start.

Top module: `io_port_decoder`

## Requirements
- R1: In the cycle after a start pulse with the status showing I/O (`bus_mem_sel`=0) and read (`bus_write`=0), `io_rd_cmd` is 1 for exactly one cycle; it is 0 at every other time.
- R2: In the cycle after a start pulse with the status showing I/O and write (`bus_write`=1), `io_wr_cmd` is 1 for exactly one cycle; it is 0 at every other time.
- R3: A cycle with `bus_mem_sel`=1 asserts no command and no select, drives nothing on the read bus, and leaves the output register unchanged.
- R4: Only address bits 15..0 are compared; bits above 15 have no effect on any select.
- R5: With `short_addr`=1 the port number is address bits 7..0 zero-extended to 16 bits, so bits 15..8 are ignored.
- R6: A port p is selected when address bits 15..1 equal p[15:1] and the lane of p is enabled. The low lane (data 7..0, even p) is enabled by address bit 0 = 0. The high lane (data 15..8, odd p) is enabled by `hi_byte_en_n`=0.
- R7: While the input port is selected (one cycle, with `io_rd_cmd`), `rdata` carries `switches` on that port's lane and 0 on the other, and `rdata_oe` has a 1 only on that lane. When it is not selected, `rdata` and `rdata_oe` are 0.
- R8: An output byte register loads its lane of `wdata` at the clock edge that ends a write cycle selecting it; it holds its value otherwise, including across reads and non-matching writes.
- R9: `led_n` equals the output register, so a 0 bit lights an indicator. A synchronous reset sets the register to all ones, so every indicator is dark.
- R10: With two output bytes at ports OUT_PORT (even) and OUT_PORT+1, a word write to OUT_PORT with both lanes enabled updates both bytes. A byte write updates only the matching byte.
- R11: A start pulse that arrives while the state machine is not in `ST_IDLE` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-cycle pulse announcing a bus cycle |
| bus_mem_sel | input | 1 | Status: 1 memory cycle, 0 I/O cycle |
| bus_write | input | 1 | Status: 1 write, 0 read |
| short_addr | input | 1 | 1 when the port number is an 8-bit fixed address |
| bus_addr | input | ADDR_W | Bus address; only bits 15..0 decoded |
| hi_byte_en_n | input | 1 | Active-low enable of data lane 15..8 |
| wdata | input | 16 | Write data bus |
| switches | input | 8 | Switch states read by the input port |
| io_rd_cmd | output | 1 | I/O read command strobe |
| io_wr_cmd | output | 1 | I/O write command strobe |
| in_sel | output | 1 | Input port select |
| out_sel | output | OUT_BYTES | Output byte selects |
| rdata | output | 16 | Read data bus contribution |
| rdata_oe | output | 2 | Per-lane read drive enables |
| led_n | output | 8*OUT_BYTES | Active-low indicator outputs |

## Verification
The assertions check on every cycle the invariants of the command strobes:
- the read and write commands are never active together;
- each command can be traced back to a start pulse with the matching status, and a memory start leads to no command;
- a select never appears without its command;
- a lane that is not selected is never driven;
- an output byte that is not written holds its value.

Only the bench scenarios can show the behaviour that depends on particular address values:
- which port numbers actually match under full and short addressing;
- how the bank enables steer word and byte accesses;
- the data that lands in the indicator register;
- that a start pulse arriving mid-cycle is dropped.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = 2;
    localparam int BUS_W     = LANE_W * NUM_LANES;
    localparam int PORT_W    = 16;
    localparam int SHORT_W   = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_IO_RD,
        ST_IO_WR,
        ST_MEM_PASS
    } cyc_state_e;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic              hi_en;
        logic              lo_en;
        logic [BUS_W-1:0]  wdata;
    } cyc_info_t;

    // a port is hit when the word address agrees and its own lane is enabled
    function automatic logic port_hit(input logic [PORT_W-1:0] addr,
                                      input logic [PORT_W-1:0] port,
                                      input logic              lo_en,
                                      input logic              hi_en);
        return (addr[PORT_W-1:1] == port[PORT_W-1:1]) && (port[0] ? hi_en : lo_en);
    endfunction
endpackage

// File: rtl/iodec_cycle_fsm.sv
module iodec_cycle_fsm
    import iodec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_start,
    input  logic              bus_mem_sel,
    input  logic              bus_write,
    input  logic              short_addr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              hi_byte_en_n,
    input  logic [BUS_W-1:0]  wdata,
    output logic              io_rd_cmd,
    output logic              io_wr_cmd,
    output cyc_info_t         info
);
    cyc_state_e        state, state_nx;
    logic [PORT_W-1:0] eff_port;
    logic              accept;

    // upper address bits are outside the I/O space and never decoded
    generate
        if (ADDR_W > PORT_W) begin : g_upper
            logic unused_upper;
            assign unused_upper = ^bus_addr[ADDR_W-1:PORT_W];
        end
    endgenerate

    assign eff_port = short_addr ? {{(PORT_W-SHORT_W){1'b0}}, bus_addr[SHORT_W-1:0]}
                                 : bus_addr[PORT_W-1:0];
    assign accept   = (state == ST_IDLE) && cyc_start;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cyc_start) begin
                    if (bus_mem_sel)    state_nx = ST_MEM_PASS;
                    else if (bus_write) state_nx = ST_IO_WR;
                    else                state_nx = ST_IO_RD;
                end
            end
            ST_IO_RD:    state_nx = ST_IDLE;
            ST_IO_WR:    state_nx = ST_IDLE;
            ST_MEM_PASS: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        io_rd_cmd = 1'b0;
        io_wr_cmd = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_IO_RD:    io_rd_cmd = 1'b1;
            ST_IO_WR:    io_wr_cmd = 1'b1;
            ST_MEM_PASS: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            info <= '0;
        end else if (accept) begin
            info.port  <= eff_port;
            info.lo_en <= ~eff_port[0];
            info.hi_en <= ~hi_byte_en_n;
            info.wdata <= wdata;
        end
    end

    assert_cmd_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        !(io_rd_cmd && io_wr_cmd));
    assert_rd_origin_R1: assert property (@(posedge clk) disable iff (rst)
        io_rd_cmd |-> $past(cyc_start && !bus_mem_sel && !bus_write));
    assert_wr_origin_R2: assert property (@(posedge clk) disable iff (rst)
        io_wr_cmd |-> $past(cyc_start && !bus_mem_sel && bus_write));
    assert_mem_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && bus_mem_sel) |=> (!io_rd_cmd && !io_wr_cmd));
    assert_one_shot_R11: assert property (@(posedge clk) disable iff (rst)
        (io_rd_cmd || io_wr_cmd) |=> (!io_rd_cmd && !io_wr_cmd));
endmodule

// File: rtl/iodec_port_match.sv
module iodec_port_match
    import iodec_pkg::*;
#(
    parameter logic [PORT_W-1:0] IN_PORT   = 16'h0019,
    parameter logic [PORT_W-1:0] OUT_PORT  = 16'h0320,
    parameter int                OUT_BYTES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 io_rd_cmd,
    input  logic                 io_wr_cmd,
    input  cyc_info_t            info,
    output logic                 in_sel,
    output logic [OUT_BYTES-1:0] out_sel
);
    assign in_sel = io_rd_cmd && port_hit(info.port, IN_PORT, info.lo_en, info.hi_en);

    generate
        for (genvar k = 0; k < OUT_BYTES; k++) begin : g_out
            localparam logic [PORT_W-1:0] PORT_K = PORT_W'(OUT_PORT + k);
            assign out_sel[k] = io_wr_cmd && port_hit(info.port, PORT_K, info.lo_en, info.hi_en);
        end
    endgenerate

    assert_in_sel_cmd_R1: assert property (@(posedge clk) disable iff (rst)
        in_sel |-> io_rd_cmd);
    assert_out_sel_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        (|out_sel) |-> io_wr_cmd);
endmodule

// File: rtl/iodec_in_port.sv
module iodec_in_port
    import iodec_pkg::*;
#(
    parameter int IN_LANE = 1
) (
    input  logic                 sel,
    input  logic [LANE_W-1:0]    switches,
    output logic [BUS_W-1:0]     rdata,
    output logic [NUM_LANES-1:0] rdata_oe
);
    generate
        for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
            if (l == IN_LANE) begin : g_drive
                assign rdata[l*LANE_W +: LANE_W] = sel ? switches : '0;
                assign rdata_oe[l]               = sel;
            end else begin : g_quiet
                assign rdata[l*LANE_W +: LANE_W] = '0;
                assign rdata_oe[l]               = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/iodec_out_port.sv
module iodec_out_port
    import iodec_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  logic [BUS_W-1:0]  wdata,
    output logic [LANE_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '1;
        else if (wen) q <= wdata[LANE*LANE_W +: LANE_W];
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wen |=> $stable(q));
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
    import iodec_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [PORT_W-1:0] IN_PORT   = 16'h0019,
    parameter logic [PORT_W-1:0] OUT_PORT  = 16'h0320,
    parameter int                OUT_BYTES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cyc_start,
    input  logic                   bus_mem_sel,
    input  logic                   bus_write,
    input  logic                   short_addr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   hi_byte_en_n,
    input  logic [15:0]            wdata,
    input  logic [7:0]             switches,
    output logic                   io_rd_cmd,
    output logic                   io_wr_cmd,
    output logic                   in_sel,
    output logic [OUT_BYTES-1:0]   out_sel,
    output logic [15:0]            rdata,
    output logic [1:0]             rdata_oe,
    output logic [8*OUT_BYTES-1:0] led_n
);
    localparam int IN_LANE = int'(IN_PORT[0]);

    cyc_info_t info;

    iodec_cycle_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cyc_start    (cyc_start),
        .bus_mem_sel  (bus_mem_sel),
        .bus_write    (bus_write),
        .short_addr   (short_addr),
        .bus_addr     (bus_addr),
        .hi_byte_en_n (hi_byte_en_n),
        .wdata        (wdata),
        .io_rd_cmd    (io_rd_cmd),
        .io_wr_cmd    (io_wr_cmd),
        .info         (info)
    );

    iodec_port_match #(
        .IN_PORT   (IN_PORT),
        .OUT_PORT  (OUT_PORT),
        .OUT_BYTES (OUT_BYTES)
    ) u_match (
        .clk       (clk),
        .rst       (rst),
        .io_rd_cmd (io_rd_cmd),
        .io_wr_cmd (io_wr_cmd),
        .info      (info),
        .in_sel    (in_sel),
        .out_sel   (out_sel)
    );

    iodec_in_port #(.IN_LANE(IN_LANE)) u_in (
        .sel      (in_sel),
        .switches (switches),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    generate
        for (genvar k = 0; k < OUT_BYTES; k++) begin : g_outreg
            localparam logic [PORT_W-1:0] PORT_K = PORT_W'(OUT_PORT + k);
            iodec_out_port #(.LANE(int'(PORT_K[0]))) u_out (
                .clk   (clk),
                .rst   (rst),
                .wen   (out_sel[k]),
                .wdata (info.wdata),
                .q     (led_n[k*LANE_W +: LANE_W])
            );
        end
    endgenerate

    assert_lane_released_R7: assert property (@(posedge clk) disable iff (rst)
        !in_sel |-> (rdata == '0 && rdata_oe == '0));
    assert_lane_single_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rdata_oe));
    assert_mem_no_sel_R3: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && bus_mem_sel && !io_rd_cmd && !io_wr_cmd) |=> (!in_sel && out_sel == '0));
endmodule

// File: tb/test_io_port_decoder.sv
`timescale 1ns/1ps
module test_io_port_decoder;
    typedef struct packed {
        logic        mem;
        logic        wr;
        logic        sht;
        logic [31:0] addr;
        logic        hin;
        logic [15:0] wd;
        logic [7:0]  sw;
        logic        e_rd;
        logic        e_wr;
        logic        e_in;
        logic [1:0]  e_out;
        logic [15:0] e_rdata;
        logic [1:0]  e_oe;
        logic [15:0] e_led;
    } vec_t;

    localparam int NV = 16;
    // input port 0x0019 (high lane), output bytes 0x0320 (low) and 0x0321 (high)
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,32'h0000_0019,1'b0,16'h0000,8'hA5, 1'b1,1'b0,1'b1,2'b00,16'hA500,2'b10,16'hFFFF}, // R1 R7
        '{1'b0,1'b0,1'b0,32'hABCD_0019,1'b0,16'h0000,8'h3C, 1'b1,1'b0,1'b1,2'b00,16'h3C00,2'b10,16'hFFFF}, // R4
        '{1'b0,1'b0,1'b0,32'h1234_5619,1'b0,16'h0000,8'h3C, 1'b1,1'b0,1'b0,2'b00,16'h0000,2'b00,16'hFFFF}, // R4 miss
        '{1'b0,1'b0,1'b1,32'h1234_5619,1'b0,16'h0000,8'h3C, 1'b1,1'b0,1'b1,2'b00,16'h3C00,2'b10,16'hFFFF}, // R5
        '{1'b0,1'b0,1'b0,32'h0000_0019,1'b1,16'h0000,8'h5A, 1'b1,1'b0,1'b0,2'b00,16'h0000,2'b00,16'hFFFF}, // R6 lane off
        '{1'b0,1'b0,1'b0,32'h0000_0018,1'b0,16'h0000,8'h81, 1'b1,1'b0,1'b1,2'b00,16'h8100,2'b10,16'hFFFF}, // R6 word read
        '{1'b1,1'b0,1'b0,32'h0000_0019,1'b0,16'h0000,8'h81, 1'b0,1'b0,1'b0,2'b00,16'h0000,2'b00,16'hFFFF}, // R3
        '{1'b0,1'b1,1'b0,32'h0000_0320,1'b0,16'h1234,8'h00, 1'b0,1'b1,1'b0,2'b11,16'h0000,2'b00,16'h1234}, // R2 R10
        '{1'b0,1'b1,1'b0,32'h0000_0320,1'b1,16'hABCD,8'h00, 1'b0,1'b1,1'b0,2'b01,16'h0000,2'b00,16'h12CD}, // R10 low byte
        '{1'b0,1'b1,1'b0,32'h0000_0321,1'b0,16'h5678,8'h00, 1'b0,1'b1,1'b0,2'b10,16'h0000,2'b00,16'h56CD}, // R10 high byte
        '{1'b1,1'b1,1'b0,32'h0000_0320,1'b0,16'h0000,8'h00, 1'b0,1'b0,1'b0,2'b00,16'h0000,2'b00,16'h56CD}, // R3 write
        '{1'b0,1'b1,1'b0,32'hFFFF_0320,1'b0,16'h0F0F,8'h00, 1'b0,1'b1,1'b0,2'b11,16'h0000,2'b00,16'h0F0F}, // R4 write
        '{1'b0,1'b0,1'b0,32'h0000_0320,1'b0,16'h0000,8'h77, 1'b1,1'b0,1'b0,2'b00,16'h0000,2'b00,16'h0F0F}, // R8 read holds
        '{1'b0,1'b1,1'b1,32'h0000_0320,1'b0,16'h0000,8'h00, 1'b0,1'b1,1'b0,2'b00,16'h0000,2'b00,16'h0F0F}, // R5 short miss
        '{1'b0,1'b1,1'b0,32'h0000_0019,1'b0,16'h0000,8'h00, 1'b0,1'b1,1'b0,2'b00,16'h0000,2'b00,16'h0F0F}, // R8 other port
        '{1'b0,1'b1,1'b0,32'h0000_0322,1'b0,16'h0000,8'h00, 1'b0,1'b1,1'b0,2'b00,16'h0000,2'b00,16'h0F0F}  // R6 next word
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_start = 1'b0;
    logic        bus_mem_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic        short_addr = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        hi_byte_en_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [7:0]  switches = '0;
    logic        io_rd_cmd, io_wr_cmd, in_sel;
    logic [1:0]  out_sel;
    logic [15:0] rdata;
    logic [1:0]  rdata_oe;
    logic [15:0] led_n;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    io_port_decoder #(
        .ADDR_W(32), .IN_PORT(16'h0019), .OUT_PORT(16'h0320), .OUT_BYTES(2)
    ) i_io_port_decoder (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .bus_mem_sel(bus_mem_sel),
        .bus_write(bus_write), .short_addr(short_addr), .bus_addr(bus_addr),
        .hi_byte_en_n(hi_byte_en_n), .wdata(wdata), .switches(switches),
        .io_rd_cmd(io_rd_cmd), .io_wr_cmd(io_wr_cmd), .in_sel(in_sel),
        .out_sel(out_sel), .rdata(rdata), .rdata_oe(rdata_oe), .led_n(led_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        cyc_start    = 1'b1;
        bus_mem_sel  = v.mem;
        bus_write    = v.wr;
        short_addr   = v.sht;
        bus_addr     = v.addr;
        hi_byte_en_n = v.hin;
        wdata        = v.wd;
        switches     = v.sw;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset leds dark", 32'(led_n), 32'hFFFF);
        chk("R1 idle rd_cmd", 32'(io_rd_cmd), 0);
        chk("R2 idle wr_cmd", 32'(io_wr_cmd), 0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            cyc_start = 1'b0;
            chk($sformatf("R1 rd_cmd v%0d", i), 32'(io_rd_cmd), 32'(VECS[i].e_rd));
            chk($sformatf("R2 wr_cmd v%0d", i), 32'(io_wr_cmd), 32'(VECS[i].e_wr));
            chk($sformatf("R6 in_sel v%0d", i), 32'(in_sel), 32'(VECS[i].e_in));
            chk($sformatf("R6 out_sel v%0d", i), 32'(out_sel), 32'(VECS[i].e_out));
            chk($sformatf("R7 rdata v%0d", i), 32'(rdata), 32'(VECS[i].e_rdata));
            chk($sformatf("R7 rdata_oe v%0d", i), 32'(rdata_oe), 32'(VECS[i].e_oe));
            @(negedge clk);
            chk($sformatf("R8 led_n v%0d", i), 32'(led_n), 32'(VECS[i].e_led));
            chk($sformatf("R1 rd_cmd one cycle v%0d", i), 32'(io_rd_cmd | io_wr_cmd), 0);
        end

        // R11: a start held into the busy state is dropped
        drive('{1'b0,1'b1,1'b0,32'h0000_0320,1'b0,16'hAAAA,8'h00,
                1'b0,1'b0,1'b0,2'b00,16'h0000,2'b00,16'h0000});
        @(negedge clk);
        wdata = 16'h5555;
        @(negedge clk);
        cyc_start = 1'b0;
        chk("R11 busy start ignored wr_cmd", 32'(io_wr_cmd), 0);
        chk("R11 first write kept", 32'(led_n), 32'hAAAA);
        @(negedge clk);
        chk("R11 no second write", 32'(led_n), 32'hAAAA);

        // R9: reset again returns every indicator to dark
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset after writes", 32'(led_n), 32'hFFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule